// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a parallel NOR flash controller. It watches every bus cycle and recognises the unlock-prefixed write sequences of the flash command set. When a sequence completes, it raises a one-clock strobe naming the command. The address and data of the final write are captured beside the strobe. The recognised commands are reset, autoselect entry, word program, chip erase and sector erase. While an erase is running, the block also recognises single-write suspend and resume requests.

Read cycles and idle clocks that fall between the writes of a sequence leave the sequence where it was. A write that does not fit the next expected step drops the sequence back to idle. Such a write is not reused as the first step of a new sequence, with one exception: a reset write of F0h is honoured wherever it appears. The embedded program and erase algorithms, the array and the protection logic are driven from the strobes. They are not part of this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, every strobe output is low and both capture outputs are zero.
- R2: A write of data F0h at any address raises `resetStb` and returns the sequence to idle. This holds in every sequence state except the one awaiting program data.
- R3: A sequence opens with a write of AAh to address 555h followed by a write of 55h to address 2AAh. Only the low 12 address bits take part in these address compares, so set upper address bits do not matter.
- R4: After the two unlock writes, a write of A0h to 555h arms word program. The next write is then taken as program data whatever its address or value, including F0h. It raises `progStb`, with `capAddr`/`capData` equal to that write.
- R5: Unlock, 555h/80h, a second unlock, then 555h/10h raises `chipEraseStb`.
- R6: The same five leading writes followed by a write of 30h at any address raise `sectorEraseStb`, with `capAddr` equal to that address.
- R7: Unlock followed by a write of 90h to 555h raises `autoselStb`.
- R8: A write whose address or data does not fit the next step returns the sequence to idle without starting a new one. A write other than F0h that arrives after the sequence has been dropped raises no strobe.
- R9: Bus cycles that are reads (`busValid`=1, `busWrite`=0) and clocks with `busValid`=0 neither advance nor abort a sequence. A read carrying F0h raises no strobe.
- R10: With `eraseRunning`=1 and the sequence idle, a write of B0h raises `suspendStb` and a write of 30h raises `resumeStb`. With `eraseRunning`=0, these writes raise nothing.
- R11: Each strobe is registered. It is high for exactly the one clock after the edge that samples the final write, and at most one strobe is high at a time. Every strobe loads `capAddr`/`capData` with that final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus cycle is presented this clock |
| busWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| busAddr | input | AW | Word address of the cycle |
| busData | input | 8 | Low data byte of the cycle |
| eraseRunning | input | 1 | An embedded erase is in progress |
| resetStb | output | 1 | Reset command seen |
| autoselStb | output | 1 | Autoselect entry seen |
| progStb | output | 1 | Word program data write seen |
| chipEraseStb | output | 1 | Chip erase seen |
| sectorEraseStb | output | 1 | Sector erase seen |
| suspendStb | output | 1 | Erase suspend request |
| resumeStb | output | 1 | Erase resume request |
| capAddr | output | AW | Address of the write that completed the last command |
| capData | output | 8 | Data of the write that completed the last command |

## Verification
The hardest situations to reach from the ports have two parts: a sequence is left half done, and what happens next must be observed. One case is a dropped sequence that must not restart from the write that dropped it. The other is a program sequence whose data happens to be F0h, which must not be mistaken for a reset. The stimulus builds these with deliberate near-miss writes: a repeated first unlock, an unlock address with one bit off, and an F0h program datum. After each near miss, it continues with the writes that would have completed the command had the sequence survived. The only visible sign of the hidden state is then the presence or absence of a strobe on those later writes. Reads and idle clocks are interleaved within sequences to show that they leave that state alone.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    CK_NONE, CK_RESET, CK_AUTOSEL, CK_PROG, CK_CHIP, CK_SECTOR, CK_SUSPEND, CK_RESUME
  } cmdKind_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERS1, SQ_ERS2, SQ_ERS3
  } seqState_e;

  // Datapath -> control: what the current bus cycle looks like
  typedef struct packed {
    logic isWrite;
    logic lo555;
    logic lo2AA;
    logic dAA;
    logic d55;
    logic dA0;
    logic d80;
    logic d90;
    logic d10;
    logic d30;
    logic dB0;
    logic dF0;
  } busMatch_t;

  // Control -> datapath: which command completes on this cycle
  typedef struct packed {
    logic     fire;
    cmdKind_e kind;
  } ctlStrobe_t;

  localparam logic [11:0] ADR_FIRST  = 12'h555;
  localparam logic [11:0] ADR_SECOND = 12'h2AA;

endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int AW       = 23,
  parameter int UNLOCK_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [7:0]    busData,
  input  ctlStrobe_t    stb,
  output busMatch_t     match,
  output logic          resetStb,
  output logic          autoselStb,
  output logic          progStb,
  output logic          chipEraseStb,
  output logic          sectorEraseStb,
  output logic          suspendStb,
  output logic          resumeStb,
  output logic [AW-1:0] capAddr,
  output logic [7:0]    capData
);

  localparam logic [UNLOCK_W-1:0] CMP_FIRST  = UNLOCK_W'(ADR_FIRST);
  localparam logic [UNLOCK_W-1:0] CMP_SECOND = UNLOCK_W'(ADR_SECOND);

  logic [UNLOCK_W-1:0] lowAddr;
  assign lowAddr = busAddr[UNLOCK_W-1:0];

  always_comb begin
    match.isWrite = busValid && busWrite;
    match.lo555   = (lowAddr == CMP_FIRST);
    match.lo2AA   = (lowAddr == CMP_SECOND);
    match.dAA     = (busData == 8'hAA);
    match.d55     = (busData == 8'h55);
    match.dA0     = (busData == 8'hA0);
    match.d80     = (busData == 8'h80);
    match.d90     = (busData == 8'h90);
    match.d10     = (busData == 8'h10);
    match.d30     = (busData == 8'h30);
    match.dB0     = (busData == 8'hB0);
    match.dF0     = (busData == 8'hF0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resetStb       <= 1'b0;
      autoselStb     <= 1'b0;
      progStb        <= 1'b0;
      chipEraseStb   <= 1'b0;
      sectorEraseStb <= 1'b0;
      suspendStb     <= 1'b0;
      resumeStb      <= 1'b0;
      capAddr        <= '0;
      capData        <= '0;
    end else begin
      resetStb       <= stb.fire && (stb.kind == CK_RESET);
      autoselStb     <= stb.fire && (stb.kind == CK_AUTOSEL);
      progStb        <= stb.fire && (stb.kind == CK_PROG);
      chipEraseStb   <= stb.fire && (stb.kind == CK_CHIP);
      sectorEraseStb <= stb.fire && (stb.kind == CK_SECTOR);
      suspendStb     <= stb.fire && (stb.kind == CK_SUSPEND);
      resumeStb      <= stb.fire && (stb.kind == CK_RESUME);
      if (stb.fire) begin
        capAddr <= busAddr;
        capData <= busData;
      end
    end
  end

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eraseRunning,
  input  busMatch_t  match,
  output ctlStrobe_t stb
);

  seqState_e seqQ, seqD;
  cmdKind_e  kind;

  always_comb begin
    seqD = seqQ;
    kind = CK_NONE;
    if (match.isWrite) begin
      if (seqQ == SQ_PGM) begin
        // any write here is program data, F0h included
        kind = CK_PROG;
        seqD = SQ_IDLE;
      end else if (match.dF0) begin
        kind = CK_RESET;
        seqD = SQ_IDLE;
      end else begin
        seqD = SQ_IDLE;
        unique case (seqQ)
          SQ_IDLE: begin
            if (match.lo555 && match.dAA)      seqD = SQ_UNL1;
            else if (eraseRunning && match.dB0) kind = CK_SUSPEND;
            else if (eraseRunning && match.d30) kind = CK_RESUME;
          end
          SQ_UNL1: if (match.lo2AA && match.d55) seqD = SQ_UNL2;
          SQ_UNL2: begin
            if (match.lo555 && match.dA0)      seqD = SQ_PGM;
            else if (match.lo555 && match.d80) seqD = SQ_ERS1;
            else if (match.lo555 && match.d90) kind = CK_AUTOSEL;
          end
          SQ_ERS1: if (match.lo555 && match.dAA) seqD = SQ_ERS2;
          SQ_ERS2: if (match.lo2AA && match.d55) seqD = SQ_ERS3;
          SQ_ERS3: begin
            if (match.lo555 && match.d10) kind = CK_CHIP;
            else if (match.d30)           kind = CK_SECTOR;
          end
          default: seqD = SQ_IDLE;
        endcase
      end
    end
  end

  assign stb.fire = (kind != CK_NONE);
  assign stb.kind = kind;

  always_ff @(posedge clk) begin
    if (!rst_n) seqQ <= SQ_IDLE;
    else        seqQ <= seqD;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW       = 23,
  parameter int UNLOCK_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [7:0]    busData,
  input  logic          eraseRunning,
  output logic          resetStb,
  output logic          autoselStb,
  output logic          progStb,
  output logic          chipEraseStb,
  output logic          sectorEraseStb,
  output logic          suspendStb,
  output logic          resumeStb,
  output logic [AW-1:0] capAddr,
  output logic [7:0]    capData
);

  busMatch_t  match;
  ctlStrobe_t stb;

  fcd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .eraseRunning (eraseRunning),
    .match        (match),
    .stb          (stb)
  );

  fcd_datapath #(.AW(AW), .UNLOCK_W(UNLOCK_W)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .busValid       (busValid),
    .busWrite       (busWrite),
    .busAddr        (busAddr),
    .busData        (busData),
    .stb            (stb),
    .match          (match),
    .resetStb       (resetStb),
    .autoselStb     (autoselStb),
    .progStb        (progStb),
    .chipEraseStb   (chipEraseStb),
    .sectorEraseStb (sectorEraseStb),
    .suspendStb     (suspendStb),
    .resumeStb      (resumeStb),
    .capAddr        (capAddr),
    .capData        (capData)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int AW       = 23,
  parameter int UNLOCK_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busValid,
  input logic          busWrite,
  input logic [AW-1:0] busAddr,
  input logic [7:0]    busData,
  input logic          eraseRunning,
  input logic          resetStb,
  input logic          autoselStb,
  input logic          progStb,
  input logic          chipEraseStb,
  input logic          sectorEraseStb,
  input logic          suspendStb,
  input logic          resumeStb,
  input logic [AW-1:0] capAddr,
  input logic [7:0]    capData
);

  logic [6:0] allStb;
  assign allStb = {resumeStb, suspendStb, sectorEraseStb, chipEraseStb,
                   progStb, autoselStb, resetStb};

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(allStb));

  p_strobe_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (allStb != '0) |-> $past(busValid && busWrite));

  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (allStb != '0) |-> (capAddr == $past(busAddr) && capData == $past(busData)));

  p_reset_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resetStb |-> ($past(busData) == 8'hF0));

  p_chip_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chipEraseStb |-> ($past(busData) == 8'h10 &&
                      $past(busAddr[UNLOCK_W-1:0]) == UNLOCK_W'(12'h555)));

  p_sector_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sectorEraseStb |-> ($past(busData) == 8'h30));

  p_autosel_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    autoselStb |-> ($past(busData) == 8'h90 &&
                    $past(busAddr[UNLOCK_W-1:0]) == UNLOCK_W'(12'h555)));

  p_suspend_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (suspendStb || resumeStb) |-> $past(eraseRunning));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (allStb != '0) |=> ((allStb & $past(allStb)) == '0 || $past(busValid && busWrite)));

endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .UNLOCK_W(UNLOCK_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int AW = 23;
  // expected strobe bit order: {resume,suspend,sector,chip,prog,autosel,reset}
  localparam logic [6:0] E_NONE = 7'b0000000;
  localparam logic [6:0] E_RST  = 7'b0000001;
  localparam logic [6:0] E_AUTO = 7'b0000010;
  localparam logic [6:0] E_PROG = 7'b0000100;
  localparam logic [6:0] E_CHIP = 7'b0001000;
  localparam logic [6:0] E_SECT = 7'b0010000;
  localparam logic [6:0] E_SUSP = 7'b0100000;
  localparam logic [6:0] E_RESM = 7'b1000000;

  typedef struct {
    logic [6:0]    stb;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0]    busData = '0;
  logic          eraseRunning = 1'b0;
  logic          resetStb, autoselStb, progStb, chipEraseStb, sectorEraseStb;
  logic          suspendStb, resumeStb;
  logic [AW-1:0] capAddr;
  logic [7:0]    capData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  item_t expQ[$];

  always #10 clk = ~clk;

  flash_cmd_decoder #(.AW(AW)) u_dut (.*);

  task automatic cyc(input logic v, input logic w, input logic [AW-1:0] a,
                     input logic [7:0] d, input logic ers,
                     input logic [6:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busData = d; eraseRunning = ers;
    @(posedge clk);
    it.stb = e; it.addr = a; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic [6:0] e, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, e, tag);
  endtask

  task automatic unlock(input string tag);
    wr(23'h000555, 8'hAA, E_NONE, tag);
    wr(23'h0002AA, 8'h55, E_NONE, tag);
  endtask

  // monitor: compare the outputs one clock after each driven cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      logic [6:0] act;
      it = expQ.pop_front();
      act = {resumeStb, suspendStb, sectorEraseStb, chipEraseStb,
             progStb, autoselStb, resetStb};
      nChecks++;
      if (act !== it.stb) begin
        nFails++;
        $display("FAIL %s strobes act=%b exp=%b", it.tag, act, it.stb);
      end else if (it.stb != E_NONE && (capAddr !== it.addr || capData !== it.data)) begin
        nFails++;
        $display("FAIL %s capture act=%h/%h exp=%h/%h", it.tag, capAddr, capData,
                 it.addr, it.data);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    nChecks++;
    if ({resumeStb, suspendStb, sectorEraseStb, chipEraseStb, progStb, autoselStb,
         resetStb} !== 7'b0 || capAddr !== '0 || capData !== 8'h00) begin
      nFails++;
      $display("FAIL R1 reset outputs act=%b/%h/%h exp=0/0/0",
               {resumeStb, suspendStb, sectorEraseStb, chipEraseStb, progStb,
                autoselStb, resetStb}, capAddr, capData);
    end
    rst_n = 1'b1;

    // R2: reset at arbitrary address, back to back
    wr(23'h1234AB, 8'hF0, E_RST, "R2 reset idle");
    wr(23'h000000, 8'hF0, E_RST, "R11 back-to-back reset");

    // R3/R4: unlock with upper bits set, program
    wr(23'h7F0555, 8'hAA, E_NONE, "R3 unlock1 upper bits");
    wr(23'h5A02AA, 8'h55, E_NONE, "R3 unlock2 upper bits");
    wr(23'h400555, 8'hA0, E_NONE, "R4 arm");
    wr(23'h123456, 8'h5A, E_PROG, "R4 program");
    cyc(1'b0, 1'b0, '0, 8'h00, 1'b0, E_NONE, "R11 strobe one clock");

    // R4: program data F0 is data
    unlock("R4 unlock");
    wr(23'h000555, 8'hA0, E_NONE, "R4 arm");
    wr(23'h00ABCD, 8'hF0, E_PROG, "R4 program F0 data");

    // R5: chip erase
    unlock("R5 unlock");
    wr(23'h000555, 8'h80, E_NONE, "R5 setup");
    unlock("R5 unlock2");
    wr(23'h000555, 8'h10, E_CHIP, "R5 chip erase");

    // R6: sector erase
    unlock("R6 unlock");
    wr(23'h000555, 8'h80, E_NONE, "R6 setup");
    unlock("R6 unlock2");
    wr(23'h3ABCDE, 8'h30, E_SECT, "R6 sector erase");

    // R7: autoselect
    unlock("R7 unlock");
    wr(23'h000555, 8'h90, E_AUTO, "R7 autoselect");

    // R8: repeated first unlock aborts and is not a new start
    wr(23'h000555, 8'hAA, E_NONE, "R8 u1");
    wr(23'h000555, 8'hAA, E_NONE, "R8 abort write");
    wr(23'h0002AA, 8'h55, E_NONE, "R8 stray");
    wr(23'h000555, 8'h90, E_NONE, "R8 no autoselect after abort");
    // R8: unlock address off by one bit
    wr(23'h000554, 8'hAA, E_NONE, "R8 bad addr");
    wr(23'h0002AA, 8'h55, E_NONE, "R8 stray");
    wr(23'h000555, 8'hA0, E_NONE, "R8 stray arm");
    wr(23'h000100, 8'h77, E_NONE, "R8 no program after bad addr");
    // R2: F0 mid-sequence resets, next writes do not continue
    unlock("R2 unlock");
    wr(23'h000777, 8'hF0, E_RST, "R2 reset mid-sequence");
    wr(23'h000555, 8'hA0, E_NONE, "R2 sequence gone");
    wr(23'h000200, 8'h11, E_NONE, "R2 sequence gone");
    // R8: erase second-unlock mismatch
    unlock("R8 unlock");
    wr(23'h000555, 8'h80, E_NONE, "R8 setup");
    wr(23'h000555, 8'hAB, E_NONE, "R8 bad erase unlock");
    wr(23'h000555, 8'h10, E_NONE, "R8 no chip erase");

    // R9: reads and idle clocks interleaved
    wr(23'h000555, 8'hAA, E_NONE, "R9 u1");
    cyc(1'b1, 1'b0, 23'h000123, 8'hF0, 1'b0, E_NONE, "R9 read F0");
    cyc(1'b0, 1'b1, 23'h000000, 8'hF0, 1'b0, E_NONE, "R9 idle");
    wr(23'h0002AA, 8'h55, E_NONE, "R9 u2");
    cyc(1'b1, 1'b0, 23'h000555, 8'h80, 1'b0, E_NONE, "R9 read");
    wr(23'h000555, 8'hA0, E_NONE, "R9 arm");
    cyc(1'b1, 1'b0, 23'h000999, 8'h33, 1'b0, E_NONE, "R9 read");
    wr(23'h0FEDCB, 8'hC3, E_PROG, "R9 program after reads");

    // R10: suspend / resume
    cyc(1'b1, 1'b1, 23'h000042, 8'hB0, 1'b1, E_SUSP, "R10 suspend");
    cyc(1'b1, 1'b1, 23'h000043, 8'h30, 1'b1, E_RESM, "R10 resume");
    cyc(1'b1, 1'b1, 23'h000042, 8'hB0, 1'b0, E_NONE, "R10 suspend idle ignored");
    cyc(1'b1, 1'b1, 23'h000043, 8'h30, 1'b0, E_NONE, "R10 resume idle ignored");
    cyc(1'b1, 1'b0, 23'h000042, 8'hB0, 1'b1, E_NONE, "R10 read B0 ignored");

    cyc(1'b0, 1'b0, '0, 8'h00, 1'b0, E_NONE, "tail");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule